// File: doc/BRIEF.md
# Audio Codec Link Power and Reset Sequencer

This block controls the power state of the serial link to an audio codec. On request it moves the link into low-power mode, but only once every transmit and receive path has gone idle. The link's bit clock and serial data-in lines must also have stayed low for a set quiet interval. From low-power mode it can wake the link in one of two ways. A warm wake raises the link sync line for at least 1.3 µs. A cold wake pulls the link reset line low for at least 1 µs. After either wake the block waits for the codec's bit clock to start toggling before it reports normal mode again. If the clock stays silent, a timeout raises the error flag.

Requests that are not legal in the current mode are refused and flagged. These are a forced sync or a forced reset outside low-power mode. The block also owns the per-slot transmit and receive enables. Setting an enable takes effect at once. Clearing an enable waits until that slot's busy indication drops.

Pulse widths are counted in cycles of the block clock and derived from the clock frequency parameter, rounding up. With the default 100 MHz clock the warm pulse is 130 cycles and the cold pulse is 100 cycles. The bit clock and data-in monitors come from another clock domain. Each passes through a two-flop synchronizer before use.

Top module: `aclink_pwr_seq`

## Requirements
- R1: After reset, link_sync is 0, link_reset_n is 1, low_power is 0, req_err is 0 and every slot_en bit is 0.
- R2: After lp_req, low_power does not rise while any bit of tx_busy or rx_busy is 1. Once the busy bits are all 0 and the line monitors are already quietly low, low_power rises QUIET_CYC cycles later.
- R3: Low-power entry also requires bitclk_mon and sdin_mon both low for QUIET_CYC consecutive synchronized cycles. With busy idle, a drop of the last line to go low makes low_power rise QUIET_CYC+2 cycles later, counting the two synchronizer stages.
- R4: warm_req in low-power mode drives link_sync to 1 for exactly ceil(CLK_HZ × 1.3 µs) cycles, starting the cycle after the request. low_power stays 1 during the pulse.
- R5: warm_req outside low-power mode leaves link_sync at 0 and makes req_err 1 in the following cycle, for one cycle.
- R6: cold_req in low-power mode drives link_reset_n to 0 for exactly ceil(CLK_HZ × 1.0 µs) cycles, starting the cycle after the request.
- R7: cold_req outside low-power mode leaves link_reset_n at 1 and makes req_err 1 in the following cycle, for one cycle.
- R8: After a wake pulse ends, low_power returns to 0 once EDGE_CNT synchronized bit clock transitions have been seen. With bitclk_mon toggling every cycle from the first cycle after the pulse, this happens EDGE_CNT+2 cycles after the pulse ends.
- R9: If fewer than EDGE_CNT transitions arrive within WAKE_TO cycles after a wake pulse ends, req_err is 1 for one cycle, exactly WAKE_TO cycles after the pulse ends. The block then stays in low-power mode.
- R10: slot_en[i] becomes 1 the cycle after slot_en_req[i] is 1. A 0 on slot_en_req[i] clears slot_en[i] only in a cycle where slot_busy[i] is 0.
- R11: When warm_req and cold_req arrive together in low-power mode, the cold reset pulse is issued and link_sync stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_req | input | 1 | Request to enter low-power mode |
| warm_req | input | 1 | Request for a warm wake (sync pulse) |
| cold_req | input | 1 | Request for a cold wake (reset pulse) |
| tx_busy | input | N_PATHS | Transmit path busy indications |
| rx_busy | input | N_PATHS | Receive path busy indications |
| bitclk_mon | input | 1 | Asynchronous monitor of the link bit clock |
| sdin_mon | input | 1 | Asynchronous monitor of the serial data-in line |
| slot_en_req | input | N_SLOTS | Requested per-slot enable levels |
| slot_busy | input | N_SLOTS | Per-slot busy indications |
| slot_en | output | N_SLOTS | Effective per-slot enables |
| link_sync | output | 1 | Link sync drive (warm wake pulse) |
| link_reset_n | output | 1 | Active-low link reset drive |
| low_power | output | 1 | Link is in low-power mode or waking |
| req_err | output | 1 | One-cycle pulse on an illegal request or a wake timeout |

## Verification
A wrong state register shows up in the cycle after it goes wrong, at one of three outputs. It appears on link_sync or link_reset_n if a pulse starts when it should not, or stops early or late. It appears on low_power if the mode changes early or fails to change. The bench therefore measures every latency and pulse width to the exact cycle, not within a bound. A quiet or edge counter that is off by one gives a count that differs by one. A busy mask that is decoded wrongly lets low_power rise during the sweep. A slot enable that clears too early drops slot_en while that slot's busy input is still high.

// File: rtl/aclink_pkg.sv
package aclink_pkg;

   typedef enum logic [2:0] {
      ST_NORMAL,
      ST_ENTER,
      ST_LOWPWR,
      ST_WARM,
      ST_COLD,
      ST_WAKE
   } seq_state_t;

   function automatic int ceil_cycles(input int clk_hz, input int width_ns);
      longint prod;
      prod = longint'(clk_hz) * longint'(width_ns);
      return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
   endfunction

endpackage

// File: rtl/aclink_sync.sv
module aclink_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int SW = STAGES * W;

   if (STAGES < 2) begin : g_bad_stages
      $error("aclink_sync: STAGES must be at least 2");
   end

   logic [SW-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SW-W-1:0], d};
   end

   assign q = chain[SW-1 -: W];
endmodule

// File: rtl/aclink_slot_gate.sv
module aclink_slot_gate #(
   parameter int N_SLOTS = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_SLOTS-1:0] en_req,
   input  logic [N_SLOTS-1:0] busy,
   output logic [N_SLOTS-1:0] en
);
   for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)        en[i] <= 1'b0;
         else if (en_req[i]) en[i] <= 1'b1;
         else if (!busy[i])  en[i] <= 1'b0;
      end

      // R10
      slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (en[i] && busy[i]) |=> en[i])
         else $error("slot %0d enable dropped while busy", i);
   end
endmodule

// File: rtl/aclink_seq_fsm.sv
module aclink_seq_fsm
   import aclink_pkg::*;
#(
   parameter int N_PATHS   = 4,
   parameter int WARM_CYC  = 130,
   parameter int COLD_CYC  = 100,
   parameter int QUIET_CYC = 8,
   parameter int EDGE_CNT  = 4,
   parameter int WAKE_TO   = 1000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lp_req,
   input  logic               warm_req,
   input  logic               cold_req,
   input  logic [N_PATHS-1:0] tx_busy,
   input  logic [N_PATHS-1:0] rx_busy,
   input  logic               bclk_s,
   input  logic               sdin_s,
   output logic               link_sync,
   output logic               link_reset_n,
   output logic               low_power,
   output logic               req_err
);
   localparam int M1   = (WARM_CYC > COLD_CYC) ? WARM_CYC : COLD_CYC;
   localparam int M2   = (WAKE_TO > QUIET_CYC) ? WAKE_TO : QUIET_CYC;
   localparam int MAXC = (M1 > M2) ? M1 : M2;
   localparam int CW   = $clog2(MAXC + 1);
   localparam int EW   = $clog2(EDGE_CNT + 1);

   seq_state_t    state, nxt;
   logic [CW-1:0] cnt, cnt_nxt;
   logic [EW-1:0] edges, edges_nxt;
   logic          bclk_prev, toggle, quiet, err_nxt;

   assign toggle = bclk_s ^ bclk_prev;
   assign quiet  = ~|{tx_busy, rx_busy} && !bclk_s && !sdin_s;

   always_comb begin
      nxt       = state;
      cnt_nxt   = cnt + CW'(1);
      edges_nxt = edges;
      err_nxt   = 1'b0;
      case (state)
         ST_NORMAL: begin
            cnt_nxt = '0;
            if (warm_req || cold_req) err_nxt = 1'b1;
            else if (lp_req)          nxt     = ST_ENTER;
         end
         ST_ENTER: begin
            if (warm_req || cold_req) err_nxt = 1'b1;
            if (!quiet) cnt_nxt = '0;
            else if (cnt == CW'(QUIET_CYC - 1)) begin
               nxt     = ST_LOWPWR;
               cnt_nxt = '0;
            end
         end
         ST_LOWPWR: begin
            cnt_nxt   = '0;
            edges_nxt = '0;
            if (cold_req)      nxt = ST_COLD;
            else if (warm_req) nxt = ST_WARM;
         end
         ST_WARM: begin
            if (cnt == CW'(WARM_CYC - 1)) begin
               nxt       = ST_WAKE;
               cnt_nxt   = '0;
               edges_nxt = '0;
            end
         end
         ST_COLD: begin
            if (cnt == CW'(COLD_CYC - 1)) begin
               nxt       = ST_WAKE;
               cnt_nxt   = '0;
               edges_nxt = '0;
            end
         end
         ST_WAKE: begin
            if (toggle) edges_nxt = edges + EW'(1);
            if (toggle && edges == EW'(EDGE_CNT - 1)) begin
               nxt     = ST_NORMAL;
               cnt_nxt = '0;
            end else if (cnt == CW'(WAKE_TO - 1)) begin
               nxt     = ST_LOWPWR;
               cnt_nxt = '0;
               err_nxt = 1'b1;
            end
         end
         default: nxt = ST_NORMAL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_NORMAL;
         cnt       <= '0;
         edges     <= '0;
         bclk_prev <= 1'b0;
         req_err   <= 1'b0;
      end else begin
         state     <= nxt;
         cnt       <= cnt_nxt;
         edges     <= edges_nxt;
         bclk_prev <= bclk_s;
         req_err   <= err_nxt;
      end
   end

   assign link_sync    = (state == ST_WARM);
   assign link_reset_n = (state != ST_COLD);
   assign low_power    = (state == ST_LOWPWR) || (state == ST_WARM) ||
                         (state == ST_COLD)   || (state == ST_WAKE);

   // Run-length counters for the pulse-width checks.
   logic [CW:0] sync_run, rst_run;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_run <= '0;
         rst_run  <= '0;
      end else begin
         sync_run <= link_sync     ? sync_run + (CW+1)'(1) : '0;
         rst_run  <= !link_reset_n ? rst_run  + (CW+1)'(1) : '0;
      end
   end

   // R2
   lp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(low_power) |-> $past(~|{tx_busy, rx_busy}))
      else $error("low power entered with a busy path");

   // R3
   lp_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(low_power) |-> $past(!bclk_s && !sdin_s))
      else $error("low power entered with link lines active");

   // R4
   warm_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_sync) |-> (sync_run == (CW+1)'(WARM_CYC)))
      else $error("warm sync pulse width wrong");

   // R6
   cold_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_reset_n) |-> (rst_run == (CW+1)'(COLD_CYC)))
      else $error("cold reset pulse width wrong");

   // R5
   warm_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!low_power && warm_req) |=> (req_err && !link_sync))
      else $error("warm request outside low power not refused");

   // R7
   cold_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!low_power && cold_req) |=> (req_err && link_reset_n))
      else $error("cold request outside low power not refused");
endmodule

// File: rtl/aclink_pwr_seq.sv
module aclink_pwr_seq
   import aclink_pkg::*;
#(
   parameter int CLK_HZ    = 100_000_000,
   parameter int WARM_NS   = 1300,
   parameter int COLD_NS   = 1000,
   parameter int N_PATHS   = 4,
   parameter int N_SLOTS   = 3,
   parameter int QUIET_CYC = 8,
   parameter int EDGE_CNT  = 4,
   parameter int WAKE_TO   = 1000,
   parameter int SYNC_STG  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lp_req,
   input  logic               warm_req,
   input  logic               cold_req,
   input  logic [N_PATHS-1:0] tx_busy,
   input  logic [N_PATHS-1:0] rx_busy,
   input  logic               bitclk_mon,
   input  logic               sdin_mon,
   input  logic [N_SLOTS-1:0] slot_en_req,
   input  logic [N_SLOTS-1:0] slot_busy,
   output logic [N_SLOTS-1:0] slot_en,
   output logic               link_sync,
   output logic               link_reset_n,
   output logic               low_power,
   output logic               req_err
);
   localparam int WARM_CYC = ceil_cycles(CLK_HZ, WARM_NS);
   localparam int COLD_CYC = ceil_cycles(CLK_HZ, COLD_NS);

   if (CLK_HZ < 1_000_000) begin : g_bad_clk
      $error("aclink_pwr_seq: CLK_HZ too low for the pulse timing");
   end
   if (QUIET_CYC < 1 || EDGE_CNT < 1 || WAKE_TO < 2) begin : g_bad_cnt
      $error("aclink_pwr_seq: QUIET_CYC, EDGE_CNT and WAKE_TO out of range");
   end
   if (N_PATHS < 1 || N_SLOTS < 1) begin : g_bad_width
      $error("aclink_pwr_seq: N_PATHS and N_SLOTS must be positive");
   end

   logic [1:0] lines_s;

   aclink_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bitclk_mon, sdin_mon}),
      .q     (lines_s)
   );

   aclink_seq_fsm #(
      .N_PATHS   (N_PATHS),
      .WARM_CYC  (WARM_CYC),
      .COLD_CYC  (COLD_CYC),
      .QUIET_CYC (QUIET_CYC),
      .EDGE_CNT  (EDGE_CNT),
      .WAKE_TO   (WAKE_TO)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .lp_req       (lp_req),
      .warm_req     (warm_req),
      .cold_req     (cold_req),
      .tx_busy      (tx_busy),
      .rx_busy      (rx_busy),
      .bclk_s       (lines_s[1]),
      .sdin_s       (lines_s[0]),
      .link_sync    (link_sync),
      .link_reset_n (link_reset_n),
      .low_power    (low_power),
      .req_err      (req_err)
   );

   aclink_slot_gate #(.N_SLOTS(N_SLOTS)) u_slots (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_req (slot_en_req),
      .busy   (slot_busy),
      .en     (slot_en)
   );

   // R11
   cold_over_warm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(link_sync && !link_reset_n))
      else $error("sync and reset driven together");
endmodule

// File: tb/aclink_pwr_seq_bench.sv
`timescale 1ns/1ps
module aclink_pwr_seq_bench;
   localparam int CLK_HZ  = 10_000_000;
   localparam int NP      = 2;
   localparam int NS      = 3;
   localparam int QUIET   = 4;
   localparam int EDGES   = 4;
   localparam int WTO     = 40;
   localparam int EXP_WARM = (CLK_HZ / 1000 * 1300 + 999_999) / 1_000_000;
   localparam int EXP_COLD = (CLK_HZ / 1000 * 1000 + 999_999) / 1_000_000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lp_req = 0, warm_req = 0, cold_req = 0;
   logic [NP-1:0] tx_busy = '0, rx_busy = '0;
   logic bitclk_mon = 0, sdin_mon = 0;
   logic [NS-1:0] slot_en_req = '0, slot_busy = '0;
   logic [NS-1:0] slot_en;
   logic link_sync, link_reset_n, low_power, req_err;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   aclink_pwr_seq #(
      .CLK_HZ(CLK_HZ), .N_PATHS(NP), .N_SLOTS(NS),
      .QUIET_CYC(QUIET), .EDGE_CNT(EDGES), .WAKE_TO(WTO)
   ) u_aclink_pwr_seq (
      .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .warm_req(warm_req),
      .cold_req(cold_req), .tx_busy(tx_busy), .rx_busy(rx_busy),
      .bitclk_mon(bitclk_mon), .sdin_mon(sdin_mon),
      .slot_en_req(slot_en_req), .slot_busy(slot_busy), .slot_en(slot_en),
      .link_sync(link_sync), .link_reset_n(link_reset_n),
      .low_power(low_power), .req_err(req_err)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic pulse_req(input int which);
      if (which == 0) warm_req = 1'b1;
      else if (which == 1) cold_req = 1'b1;
      else begin warm_req = 1'b1; cold_req = 1'b1; end
      step();
      warm_req = 1'b0;
      cold_req = 1'b0;
   endtask

   // Counts cycles while the selected pulse is active; returns at the first inactive sample.
   task automatic pulse_len(input bit use_sync, output int n);
      n = 0;
      while ((use_sync ? link_sync : !link_reset_n) && n < 500) begin
         n++;
         step();
      end
   endtask

   task automatic wake_by_toggle(output int n);
      n = 0;
      do begin
         bitclk_mon = ~bitclk_mon;
         step();
         n++;
      end while (low_power && n < 100);
      bitclk_mon = 1'b0;
   endtask

   task automatic wait_lp(output int n);
      n = 0;
      do begin step(); n++; end while (!low_power && n < 100);
   endtask

   initial begin
      int n;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 sync", link_sync, 0);
      chk("R1 reset_n", link_reset_n, 1);
      chk("R1 low_power", low_power, 0);
      chk("R1 req_err", req_err, 0);
      chk("R1 slot_en", slot_en, 0);

      // R10 slot enable gating, every slot
      for (int s = 0; s < NS; s++) begin
         slot_en_req[s] = 1'b1;
         step();
         chk("R10 set", slot_en[s], 1);
         slot_busy[s] = 1'b1;
         slot_en_req[s] = 1'b0;
         repeat (5) step();
         chk("R10 held while busy", slot_en[s], 1);
         slot_busy[s] = 1'b0;
         step();
         chk("R10 cleared when idle", slot_en[s], 0);
      end

      // R5 warm request refused in normal mode
      pulse_req(0);
      chk("R5 err", req_err, 1);
      chk("R5 no sync", link_sync, 0);
      step();
      chk("R5 err one cycle", req_err, 0);
      // R7 cold request refused in normal mode
      pulse_req(1);
      chk("R7 err", req_err, 1);
      chk("R7 no reset", link_reset_n, 1);
      step();
      chk("R7 err one cycle", req_err, 0);

      // R2 busy sweep: every nonzero busy mask blocks entry
      lp_req = 1'b1;
      step();
      lp_req = 1'b0;
      for (int m = 1; m < (1 << (2 * NP)); m++) begin
         {tx_busy, rx_busy} = (2 * NP)'(m);
         repeat (QUIET + 4) step();
         chk("R2 blocked by busy", low_power, 0);
      end
      {tx_busy, rx_busy} = '0;
      wait_lp(n);
      chk("R2 entry latency", n, QUIET);

      // R4 warm pulse, then R8 wake by bit clock
      pulse_req(0);
      chk("R4 sync starts", link_sync, 1);
      chk("R4 low_power during pulse", low_power, 1);
      pulse_len(1'b1, n);
      chk("R4 warm width", n, EXP_WARM);
      wake_by_toggle(n);
      chk("R8 wake after warm", n, EDGES + 2);
      chk("R8 no error", req_err, 0);

      // R3 line monitors must both be low
      bitclk_mon = 1'b1;
      sdin_mon = 1'b1;
      lp_req = 1'b1;
      step();
      lp_req = 1'b0;
      repeat (QUIET + 6) step();
      chk("R3 blocked by both lines", low_power, 0);
      bitclk_mon = 1'b0;
      repeat (QUIET + 6) step();
      chk("R3 blocked by data line", low_power, 0);
      sdin_mon = 1'b0;
      wait_lp(n);
      chk("R3 entry latency", n, QUIET + 2);

      // R6 cold pulse, then R8 wake
      pulse_req(1);
      chk("R6 reset starts", link_reset_n, 0);
      chk("R6 no sync", link_sync, 0);
      pulse_len(1'b0, n);
      chk("R6 cold width", n, EXP_COLD);
      wake_by_toggle(n);
      chk("R8 wake after cold", n, EDGES + 2);

      // R9 wake timeout
      lp_req = 1'b1;
      step();
      lp_req = 1'b0;
      wait_lp(n);
      pulse_req(0);
      pulse_len(1'b1, n);
      chk("R4 warm width again", n, EXP_WARM);
      n = 0;
      do begin step(); n++; end while (!req_err && n < 200);
      chk("R9 timeout latency", n, WTO);
      step();
      chk("R9 err one cycle", req_err, 0);
      chk("R9 stays low power", low_power, 1);

      // R11 cold wins over warm
      pulse_req(2);
      chk("R11 reset driven", link_reset_n, 0);
      chk("R11 sync quiet", link_sync, 0);
      pulse_len(1'b0, n);
      chk("R11 cold width", n, EXP_COLD);
      wake_by_toggle(n);
      chk("R11 back to normal", low_power, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule